// File: doc/BRIEF.md
# D-Channel Receive Frame Collector

This block assembles one received HDLC D-channel frame out of a 32-byte receive FIFO that sits in front of it. The FIFO side raises one of two events. The first is a pool-full event, which means a complete 32-byte chunk is waiting. The second is a message-end event, which arrives with the frame's status byte and the low bits of its byte count. The collector pulls the chunk over a valid/ready byte stream into a local frame buffer. It then pulses a release strobe so that the FIFO can free or flush that space.

When a frame ends with acceptable status and a usable length, the buffered bytes are streamed out over a valid/ready interface, with a last flag on the final byte. Frames are dropped without any output in three cases: the status is bad, the frame would overrun the buffer, or the frame is empty. A static mode input selects a variant in which every frame ends in a trailing status byte, which is stripped before output.

Back-pressure rules: the FIFO side may hold `fifo_valid_i` low at any time, and a byte moves only in a cycle where both valid and ready are high. On the output side, once `out_valid_o` is high, it and `out_data_o`/`out_last_o` hold steady until `out_ready_i` is seen high. Events are taken only in a cycle where `evt_ready_o` is high. `trailer_mode_i` is sampled when an event is taken.

Top module: `dchan_rx_collector`

## Requirements
- R1: After reset `evt_ready_o` is 1 and `fifo_ready_o`, `fifo_release_o`, `out_valid_o` and `out_last_o` are 0.
- R2: A taken pool-full event reads exactly 32 bytes from the FIFO stream into the buffer, followed by one release pulse.
- R3: A taken message-end event reads a final chunk whose length is the 5-bit `rx_cnt_lo_i`, where the value 0 stands for 32.
- R4: With `trailer_mode_i` = 0, a frame is kept only if status bit 5 (check passed) is 1, bit 6 (overflow) is 0 and bit 4 (abort) is 0; bit 7 is ignored. Otherwise no byte is read, one release pulse is given and nothing is output.
- R5: With `trailer_mode_i` = 1, a frame is kept only if bits 7 (valid frame) and 5 are 1 and bits 6 and 4 are 0. The last byte read is removed before output, and a frame left with 0 bytes is dropped after its release pulse.
- R6: If the buffered byte count plus the incoming chunk length reaches MAX_FRAME (default 300), that chunk is not read, one release pulse is given and the buffer is emptied. A message end in that case outputs nothing.
- R7: A kept frame is output in arrival order, one byte per handshake, with `out_last_o` high only on the final byte. The output holds steady while `out_ready_i` is 0.
- R8: After every message end, whether the frame was delivered or dropped, the buffer is empty, so the next frame holds only its own bytes.
- R9: Events are taken only while `evt_ready_o` is 1, and an event raised while it is 0 has no effect. If pool-full and message-end are raised in the same cycle, the message end is handled and the pool-full is ignored.
- R10: The release strobe lasts a single cycle per taken event, and `fifo_ready_o` is high only while a chunk is being read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trailer_mode_i | input | 1 | 1 selects frames that end in a status byte |
| pool_full_i | input | 1 | A full 32-byte chunk is waiting in the FIFO |
| msg_end_i | input | 1 | The frame has ended; status and count are valid |
| rx_stat_i | input | 8 | Frame status byte |
| rx_cnt_lo_i | input | 5 | Low bits of the frame byte count (0 means 32) |
| evt_ready_o | output | 1 | Collector can take an event this cycle |
| fifo_valid_i | input | 1 | FIFO byte available |
| fifo_data_i | input | 8 | FIFO byte |
| fifo_ready_o | output | 1 | Collector takes the FIFO byte |
| fifo_release_o | output | 1 | One-cycle strobe: release or flush the current FIFO chunk |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Final byte of the frame |
| out_ready_i | input | 1 | Downstream takes the output byte |

## Verification
The two functions that can meet in one cycle are event intake and the chunk or frame work that is already in progress. One case is a pool-full raised in the same cycle as a message end. The other is a pool-full poked one cycle after an event was taken, while the collector is still releasing or reading. The bench provokes both and judges them only at the ports. It counts FIFO handshakes and release strobes and collects the output frame, then compares these with a model in which the extra pool-full never happened. Random FIFO stalls and output back-pressure make the read, release and output phases land on varied cycle alignments relative to these pokes.

// File: rtl/dchan_rx_pkg.sv
package dchan_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_FREE  = 2'd2,
    ST_SEND  = 2'd3
  } rxc_state_e;

  // Status acceptance: both variants need check-ok set with overflow and
  // abort clear; the trailer variant additionally needs the frame-valid bit.
  function automatic logic stat_good(input logic trailer, input logic [7:0] st);
    logic [7:0] need_mask;
    logic [7:0] need_val;
    need_mask = trailer ? 8'hF0 : 8'h70;
    need_val  = trailer ? 8'hA0 : 8'h20;
    return (st & need_mask) == need_val;
  endfunction

endpackage

// File: rtl/dchan_rx_evt_decode.sv
module dchan_rx_evt_decode
  import dchan_rx_pkg::*;
#(
  parameter int CHUNK = 32
) (
  input  logic                     pool_full_i,
  input  logic                     msg_end_i,
  input  logic [$clog2(CHUNK)-1:0] cnt_lo_i,
  input  logic [7:0]               stat_i,
  input  logic                     trailer_i,
  output logic                     hit_o,
  output logic                     end_o,
  output logic [$clog2(CHUNK):0]   len_o,
  output logic                     ok_o
);
  localparam int CW = $clog2(CHUNK) + 1;

  assign hit_o = pool_full_i | msg_end_i;
  assign end_o = msg_end_i;
  assign ok_o  = stat_good(trailer_i, stat_i);

  always_comb begin
    if (msg_end_i && (cnt_lo_i != '0)) len_o = {1'b0, cnt_lo_i};
    else                               len_o = CW'(CHUNK);
  end

endmodule

// File: rtl/dchan_rx_frame_buf.sv
module dchan_rx_frame_buf #(
  parameter int DEPTH = 300,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [DW-1:0]            rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/dchan_rx_ctrl.sv
module dchan_rx_ctrl
  import dchan_rx_pkg::*;
#(
  parameter int MAX_FRAME = 300,
  parameter int CHUNK     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         evt_hit_i,
  input  logic                         evt_end_i,
  input  logic [$clog2(CHUNK):0]       evt_len_i,
  input  logic                         evt_ok_i,
  input  logic                         trailer_i,
  output logic                         evt_ready_o,
  input  logic                         fifo_valid_i,
  output logic                         fifo_ready_o,
  output logic                         fifo_release_o,
  output logic                         buf_we_o,
  output logic [$clog2(MAX_FRAME)-1:0] buf_waddr_o,
  output logic [$clog2(MAX_FRAME)-1:0] buf_raddr_o,
  output logic                         out_valid_o,
  output logic                         out_last_o,
  input  logic                         out_ready_i
);
  localparam int IW = $clog2(MAX_FRAME);
  localparam int CW = $clog2(CHUNK) + 1;
  localparam int SW = $clog2(MAX_FRAME + CHUNK) + 1;

  rxc_state_e    state_q;
  logic [IW-1:0] wr_q, rd_q, len_q, fin_len;
  logic [CW-1:0] rem_q;
  logic          end_q, keep_q, trl_q;
  logic [SW-1:0] fill_sum;
  logic          rd_hs, out_hs, at_last;

  assign fill_sum = SW'(wr_q) + SW'(evt_len_i);
  assign fin_len  = wr_q - {{(IW-1){1'b0}}, trl_q};
  assign at_last  = (rd_q == (len_q - IW'(1)));

  assign evt_ready_o    = (state_q == ST_IDLE);
  assign fifo_ready_o   = (state_q == ST_FETCH);
  assign fifo_release_o = (state_q == ST_FREE);
  assign out_valid_o    = (state_q == ST_SEND);
  assign out_last_o     = out_valid_o && at_last;

  assign rd_hs  = fifo_valid_i && fifo_ready_o;
  assign out_hs = out_valid_o && out_ready_i;

  assign buf_we_o    = rd_hs;
  assign buf_waddr_o = wr_q;
  assign buf_raddr_o = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= '0;
      rd_q    <= '0;
      len_q   <= '0;
      rem_q   <= '0;
      end_q   <= 1'b0;
      keep_q  <= 1'b0;
      trl_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (evt_hit_i) begin
            end_q <= evt_end_i;
            trl_q <= trailer_i;
            if (evt_end_i && !evt_ok_i) begin
              keep_q  <= 1'b0;
              state_q <= ST_FREE;
            end else if (fill_sum >= SW'(MAX_FRAME)) begin
              keep_q  <= 1'b0;
              wr_q    <= '0;
              state_q <= ST_FREE;
            end else begin
              keep_q  <= 1'b1;
              rem_q   <= evt_len_i;
              state_q <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (rd_hs) begin
            wr_q  <= wr_q + IW'(1);
            rem_q <= rem_q - CW'(1);
            if (rem_q == CW'(1)) state_q <= ST_FREE;
          end
        end
        ST_FREE: begin
          state_q <= ST_IDLE;
          if (end_q) begin
            if (keep_q && (fin_len != '0)) begin
              len_q   <= fin_len;
              rd_q    <= '0;
              state_q <= ST_SEND;
            end else begin
              wr_q <= '0;
            end
          end
        end
        ST_SEND: begin
          if (out_hs) begin
            rd_q <= rd_q + IW'(1);
            if (at_last) begin
              wr_q    <= '0;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dchan_rx_collector.sv
module dchan_rx_collector #(
  parameter int MAX_FRAME = 300,
  parameter int CHUNK     = 32,
  parameter int DW        = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     trailer_mode_i,
  input  logic                     pool_full_i,
  input  logic                     msg_end_i,
  input  logic [7:0]               rx_stat_i,
  input  logic [$clog2(CHUNK)-1:0] rx_cnt_lo_i,
  output logic                     evt_ready_o,
  input  logic                     fifo_valid_i,
  input  logic [DW-1:0]            fifo_data_i,
  output logic                     fifo_ready_o,
  output logic                     fifo_release_o,
  output logic                     out_valid_o,
  output logic [DW-1:0]            out_data_o,
  output logic                     out_last_o,
  input  logic                     out_ready_i
);
  localparam int IW = $clog2(MAX_FRAME);
  localparam int CW = $clog2(CHUNK) + 1;

  logic          evt_hit, evt_end, evt_ok;
  logic [CW-1:0] evt_len;
  logic          buf_we;
  logic [IW-1:0] buf_waddr, buf_raddr;

  dchan_rx_evt_decode #(.CHUNK(CHUNK)) u_decode (
    .pool_full_i (pool_full_i),
    .msg_end_i   (msg_end_i),
    .cnt_lo_i    (rx_cnt_lo_i),
    .stat_i      (rx_stat_i),
    .trailer_i   (trailer_mode_i),
    .hit_o       (evt_hit),
    .end_o       (evt_end),
    .len_o       (evt_len),
    .ok_o        (evt_ok)
  );

  dchan_rx_ctrl #(.MAX_FRAME(MAX_FRAME), .CHUNK(CHUNK)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .evt_hit_i      (evt_hit),
    .evt_end_i      (evt_end),
    .evt_len_i      (evt_len),
    .evt_ok_i       (evt_ok),
    .trailer_i      (trailer_mode_i),
    .evt_ready_o    (evt_ready_o),
    .fifo_valid_i   (fifo_valid_i),
    .fifo_ready_o   (fifo_ready_o),
    .fifo_release_o (fifo_release_o),
    .buf_we_o       (buf_we),
    .buf_waddr_o    (buf_waddr),
    .buf_raddr_o    (buf_raddr),
    .out_valid_o    (out_valid_o),
    .out_last_o     (out_last_o),
    .out_ready_i    (out_ready_i)
  );

  dchan_rx_frame_buf #(.DEPTH(MAX_FRAME), .DW(DW)) u_buf (
    .clk     (clk),
    .we_i    (buf_we),
    .waddr_i (buf_waddr),
    .wdata_i (fifo_data_i),
    .raddr_i (buf_raddr),
    .rdata_o (out_data_o)
  );

endmodule

// File: rtl/dchan_rx_collector_chk.sv
module dchan_rx_collector_chk #(
  parameter int MAX_FRAME = 300,
  parameter int CHUNK     = 32,
  parameter int DW        = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pool_full_i,
  input logic          msg_end_i,
  input logic          evt_ready_o,
  input logic          fifo_valid_i,
  input logic          fifo_ready_o,
  input logic          fifo_release_o,
  input logic          out_valid_o,
  input logic [DW-1:0] out_data_o,
  input logic          out_last_o,
  input logic          out_ready_i
);
  logic [15:0] chunk_rd_q;
  logic [15:0] frame_out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chunk_rd_q  <= '0;
      frame_out_q <= '0;
    end else begin
      if (fifo_release_o)                  chunk_rd_q <= '0;
      else if (fifo_valid_i && fifo_ready_o) chunk_rd_q <= chunk_rd_q + 16'd1;
      if (out_valid_o && out_ready_i)
        frame_out_q <= out_last_o ? 16'd0 : frame_out_q + 16'd1;
    end
  end

  AST_CHUNK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_rd_q <= 16'(CHUNK)); // R2

  AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    frame_out_q < 16'(MAX_FRAME)); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o))); // R7

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last_o |-> out_valid_o); // R7

  AST_EVT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ready_o && (pool_full_i || msg_end_i)) |=> !evt_ready_o); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ready_o |-> (!out_valid_o && !fifo_ready_o && !fifo_release_o)); // R9

  AST_RELEASE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_release_o |=> !fifo_release_o); // R10

  AST_READ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready_o |-> (!out_valid_o && !fifo_release_o)); // R10

endmodule

bind dchan_rx_collector dchan_rx_collector_chk #(
  .MAX_FRAME (MAX_FRAME),
  .CHUNK     (CHUNK),
  .DW        (DW)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pool_full_i    (pool_full_i),
  .msg_end_i      (msg_end_i),
  .evt_ready_o    (evt_ready_o),
  .fifo_valid_i   (fifo_valid_i),
  .fifo_ready_o   (fifo_ready_o),
  .fifo_release_o (fifo_release_o),
  .out_valid_o    (out_valid_o),
  .out_data_o     (out_data_o),
  .out_last_o     (out_last_o),
  .out_ready_i    (out_ready_i)
);

// File: tb/dchan_rx_collector_tb_top.sv
`timescale 1ns/1ps
module dchan_rx_collector_tb_top;
  localparam int MAXF = 300;
  localparam int CH   = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trailer = 1'b0, pool_full = 1'b0, msg_end = 1'b0;
  logic [7:0] stat = '0;
  logic [4:0] cnt_lo = '0;
  logic       evt_ready, fifo_ready, fifo_release, out_valid, out_last;
  logic       fifo_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] fifo_data = '0, out_data;

  int vectors = 0, fails = 0;
  int reads = 0, rels = 0, lasts = 0, last_pos = 0;
  logic [7:0] fed[$];
  logic [7:0] got[$];

  always #2.5 clk = ~clk;

  dchan_rx_collector #(.MAX_FRAME(MAXF), .CHUNK(CH), .DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .trailer_mode_i(trailer),
    .pool_full_i(pool_full), .msg_end_i(msg_end), .rx_stat_i(stat),
    .rx_cnt_lo_i(cnt_lo), .evt_ready_o(evt_ready),
    .fifo_valid_i(fifo_valid), .fifo_data_i(fifo_data),
    .fifo_ready_o(fifo_ready), .fifo_release_o(fifo_release),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_last_o(out_last),
    .out_ready_i(out_ready)
  );

  // Port monitor: handshakes are taken with pre-edge values.
  always @(posedge clk) begin
    if (rst_n) begin
      if (fifo_valid && fifo_ready) begin fed.push_back(fifo_data); reads++; end
      if (fifo_release) rels++;
      if (out_valid && out_ready) begin
        got.push_back(out_data);
        if (out_last) begin lasts++; last_pos = got.size(); end
      end
    end
  end

  // Random stalls on both streams, driven away from the active edge.
  always @(negedge clk) begin
    fifo_valid <= ($urandom_range(3) != 0);
    fifo_data  <= 8'($urandom);
    out_ready  <= ($urandom_range(2) != 0);
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_good(input bit trl, input logic [7:0] s);
    bit crc_ok, ovf, abt, vfr;
    crc_ok = s[5]; ovf = s[6]; abt = s[4]; vfr = s[7];
    if (trl) return vfr && crc_ok && !ovf && !abt;
    return crc_ok && !ovf && !abt;
  endfunction

  task automatic run_evt(input bit is_pool, input bit is_end, input logic [7:0] st,
                         input logic [4:0] cnt, input bit poke, input string req);
    int chunk, exp_reads, r0, l0, outlen, mism;
    bit drop;
    logic [7:0] exp_q[$];
    @(negedge clk);
    while (!evt_ready) @(negedge clk);
    chunk = (is_end && cnt != 0) ? int'(cnt) : CH;
    drop = 1'b0;
    if (is_end && !exp_good(trailer, st)) drop = 1'b1;
    else if (fed.size() + chunk >= MAXF)   drop = 1'b1;
    exp_reads = drop ? 0 : chunk;
    r0 = reads; l0 = rels; got.delete(); lasts = 0; last_pos = 0;
    pool_full = is_pool; msg_end = is_end; stat = st; cnt_lo = cnt;
    @(negedge clk);
    pool_full = poke; msg_end = 1'b0;   // poke lands while busy (R9)
    @(negedge clk);
    pool_full = 1'b0;
    while (!evt_ready) @(negedge clk);
    chk((reads - r0) == exp_reads, req, "bytes read", reads - r0, exp_reads);
    chk((rels - l0) == 1, "R10", "release pulses", rels - l0, 1);
    if (is_end && !drop) begin
      outlen = fed.size() - (trailer ? 1 : 0);
      for (int i = 0; i < outlen; i++) exp_q.push_back(fed[i]);
    end
    chk(got.size() == exp_q.size(), req, "frame length", got.size(), exp_q.size());
    chk(lasts == ((exp_q.size() > 0) ? 1 : 0), "R7", "last flags", lasts, (exp_q.size() > 0) ? 1 : 0);
    if (exp_q.size() > 0) begin
      chk(last_pos == exp_q.size(), "R7", "last position", last_pos, exp_q.size());
      mism = 0;
      if (got.size() == exp_q.size())
        for (int i = 0; i < exp_q.size(); i++) if (got[i] != exp_q[i]) mism++;
      chk(mism == 0, "R7", "data mismatches", mism, 0);
    end
    if (is_end || drop) fed.delete();
  endtask

  task automatic send_frame(input int npools, input logic [4:0] cnt, input logic [7:0] st,
                            input bit poke, input string req);
    for (int p = 0; p < npools; p++) run_evt(1'b1, 1'b0, 8'h00, 5'd0, poke, req);
    run_evt(1'b0, 1'b1, st, cnt, poke, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h0D1C_5EED));
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(evt_ready == 1'b1, "R1", "evt_ready", evt_ready, 1);
    chk({fifo_ready, fifo_release, out_valid, out_last} == 4'b0, "R1", "quiet outputs",
        {fifo_ready, fifo_release, out_valid, out_last}, 0);
    rst_n = 1'b1;

    trailer = 1'b0;
    send_frame(0, 5'd5,  8'h20, 1'b0, "R3");  // short base frame
    send_frame(0, 5'd0,  8'h20, 1'b0, "R3");  // count 0 means 32
    send_frame(0, 5'd7,  8'h60, 1'b0, "R4");  // overflow set: drop
    send_frame(0, 5'd7,  8'h30, 1'b0, "R4");  // abort set: drop
    send_frame(0, 5'd7,  8'h00, 1'b0, "R4");  // check-ok clear: drop
    send_frame(0, 5'd9,  8'hA0, 1'b0, "R4");  // bit 7 ignored in base mode
    send_frame(2, 5'd3,  8'h20, 1'b0, "R2");  // 67 bytes over three chunks
    send_frame(1, 5'd4,  8'h60, 1'b0, "R8");  // drop after a full chunk
    send_frame(0, 5'd6,  8'h20, 1'b0, "R8");  // next frame starts empty
    send_frame(9, 5'd11, 8'h20, 1'b0, "R6");  // 299 bytes: just fits
    send_frame(9, 5'd12, 8'h20, 1'b0, "R6");  // 300: overrun, dropped
    send_frame(10, 5'd4, 8'h20, 1'b0, "R6");  // 10th chunk overruns, then 4 bytes
    send_frame(0, 5'd3,  8'h20, 1'b1, "R9");  // pool-full poked while busy
    run_evt(1'b1, 1'b1, 8'h20, 5'd3, 1'b0, "R9"); // both events: end wins

    trailer = 1'b1;
    send_frame(0, 5'd6,  8'hA0, 1'b0, "R5");  // status byte stripped
    send_frame(0, 5'd6,  8'h20, 1'b0, "R5");  // frame-valid clear: drop
    send_frame(0, 5'd6,  8'hE0, 1'b0, "R5");  // overflow set: drop
    send_frame(0, 5'd1,  8'hA0, 1'b0, "R5");  // empty after strip: drop
    send_frame(1, 5'd0,  8'hA0, 1'b1, "R5");  // 64 read, 63 out

    for (int f = 0; f < 30; f++) begin
      logic [7:0] st;
      trailer = 1'($urandom_range(1));
      if ($urandom_range(3) == 0) st = 8'($urandom);
      else st = (trailer ? 8'hA0 : 8'h20) | 8'($urandom_range(15));
      send_frame($urandom_range(10), 5'($urandom), st, ($urandom_range(3) == 0), "R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule